// File: doc/BRIEF.md
# ECC Aggregator Interrupt Register Block

This block sits beside four ECC-protected RAMs and gathers their error events for software. Each RAM reports two kinds of event. A single-error-correct (SEC) event means the RAM corrected a flipped bit. A double-error-detect (DED) event means the RAM found an error it could not correct. Each event sets a pending bit for its RAM. For each kind, SEC and DED, the pending bits are combined with a per-RAM enable mask. The result drives a one-cycle interrupt pulse. Once that pulse has fired, it stays silent until software writes an end-of-interrupt (EOI) command to re-arm it.

The aggregator also reports two faults of its own, parity and timeout. Each is counted in a two-bit saturating field. Software can raise or lower either field through a separate up address and down address. A level interrupt stays high while any enabled field is non-zero.

A flat 32-bit register port gives software access: address, write strobe, write data, and combinational read data. The port also holds an identity register, an info register that reports the RAM count, and a vector register. The vector register selects a RAM and a read address, and it starts an indirect read. A handshake (`rd_go` out, `rd_done` back) reports when that read has finished.

Top module: `ecc_irq_regs`

## Requirements
- R1: After reset, address 0x00 reads 0x66A03201, address 0x0C reads the RAM count (4) in bits 10:0, and all pending, enable, counter and vector fields read zero with all three interrupts low.
- R2: SEC pending (0x40) and DED pending (0x140) hold one bit per RAM in bits 3:0, and all higher bits read 0. Writing 1 to a bit there sets it, and a hardware event on `sec_evt`/`ded_evt` bit i sets bit i. Writing 1 at the clear addresses 0x44/0x144 clears the bit, and reading a clear address returns the pending bits.
- R3: Enables are written through pairs of addresses. A 1 at the set address (0x80 SEC, 0x180 DED) turns the enable bit on, and a 1 at the clear address (0xC0, 0x1C0) turns it off. Zero bits leave the enable unchanged, and both addresses of a pair read back the current mask.
- R4: A hardware event and a software clear of the same pending bit in one cycle leave the bit set.
- R5: While its kind is armed, `sec_irq`/`ded_irq` goes high for exactly one cycle, in the cycle after some pending bit is also enabled. The pulse then disarms that kind.
- R6: A disarmed kind gives no pulse, even for new enabled events, until bit 0 is written as 1 at its EOI address (0x3C SEC, 0x13C DED). After that write, a pending and enabled bit fires a pulse again.
- R7: The aggregator status holds two fields: parity in bits 1:0 and timeout in bits 3:2. Both 0x208 and 0x20C read it. A write to 0x208 adds the written field values, and a write to 0x20C subtracts them. Each field saturates at 3 and at 0.
- R8: A `par_err` or `tmo_err` pulse adds one to its field, still saturating. When the pulse falls in the same cycle as a write to 0x20C, the field changes by the net amount.
- R9: The aggregator enables are set at 0x200 and cleared at 0x204, with bit 0 for parity and bit 1 for timeout, and both addresses read the mask. `agg_irq` is a level that is high exactly while some enabled field is non-zero.
- R10: In the vector register (0x08), bits 10:0 (RAM select) and 23:16 (read address) are read/write. Writing 1 to bit 15 when no read is outstanding pulses `rd_go` for one cycle, and bit 15 reads 1 until `rd_done`. `rd_done` sets bit 24, and any later write to 0x08 clears bit 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sec_evt | input | 4 | Per-RAM correctable error pulses |
| ded_evt | input | 4 | Per-RAM uncorrectable error pulses |
| par_err | input | 1 | Aggregator parity fault pulse |
| tmo_err | input | 1 | Aggregator timeout fault pulse |
| sec_irq | output | 1 | Correctable error interrupt pulse |
| ded_irq | output | 1 | Uncorrectable error interrupt pulse |
| agg_irq | output | 1 | Aggregator fault interrupt level |
| rd_go | output | 1 | Indirect read start pulse |
| rd_done | input | 1 | Indirect read completion pulse |

## Verification
Two of the block's functions can land in the same cycle. A hardware error event can meet a software write that lowers the same state: a DED event against a write to the pending-clear address, and a parity fault against a write to the status-down address. The bench provokes both by driving the event input during the very cycle it issues the write strobe. It then judges the outcome at the read port. The pending bit must still read 1, and the parity field must be unchanged, because +1 and -1 cancel.

// File: rtl/ecc_irq_pkg.sv
`timescale 1ns/1ps
package ecc_irq_pkg;
  localparam int ADDR_W  = 12;
  localparam int CNT_W   = 2;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  // register map
  localparam logic [ADDR_W-1:0] A_REV      = 12'h000;
  localparam logic [ADDR_W-1:0] A_VEC      = 12'h008;
  localparam logic [ADDR_W-1:0] A_INFO     = 12'h00C;
  localparam logic [ADDR_W-1:0] GRP_STRIDE = 12'h100;
  localparam logic [ADDR_W-1:0] A_SEC_EOI  = 12'h03C;
  localparam logic [ADDR_W-1:0] A_SEC_PEND = 12'h040;
  localparam logic [ADDR_W-1:0] A_SEC_PCLR = 12'h044;
  localparam logic [ADDR_W-1:0] A_SEC_ENS  = 12'h080;
  localparam logic [ADDR_W-1:0] A_SEC_ENC  = 12'h0C0;
  localparam logic [ADDR_W-1:0] A_DED_PEND = A_SEC_PEND + GRP_STRIDE;
  localparam logic [ADDR_W-1:0] A_DED_PCLR = A_SEC_PCLR + GRP_STRIDE;
  localparam logic [ADDR_W-1:0] A_DED_ENS  = A_SEC_ENS + GRP_STRIDE;
  localparam logic [ADDR_W-1:0] A_DED_ENC  = A_SEC_ENC + GRP_STRIDE;
  localparam logic [ADDR_W-1:0] A_AGG_ENS  = 12'h200;
  localparam logic [ADDR_W-1:0] A_AGG_ENC  = 12'h204;
  localparam logic [ADDR_W-1:0] A_AGG_UP   = 12'h208;
  localparam logic [ADDR_W-1:0] A_AGG_DN   = 12'h20C;

  // add first, then subtract, then clamp into [0, CNT_MAX]
  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W:0]   up,
                                                input logic [CNT_W-1:0] down);
    int s;
    s = int'(cur) + int'(up) - int'(down);
    if (s < 0) s = 0;
    if (s > CNT_MAX) s = CNT_MAX;
    return CNT_W'(s);
  endfunction
endpackage

// File: rtl/ecc_pulse_group.sv
`timescale 1ns/1ps
module ecc_pulse_group #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_evt,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] en_set,
  input  logic [N-1:0] en_clr,
  input  logic         eoi,
  output logic [N-1:0] pend,
  output logic [N-1:0] en,
  output logic         irq
);
  logic armed;
  logic fire;

  assign fire = armed && |(pend & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      en    <= '0;
      armed <= 1'b1;
      irq   <= 1'b0;
    end else begin
      pend <= (pend & ~sw_clr) | sw_set | hw_evt;  // set beats clear
      en   <= (en & ~en_clr) | en_set;
      if (fire)     armed <= 1'b0;
      else if (eoi) armed <= 1'b1;
      irq <= fire;
    end
  end

  a_r4_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> ((pend & $past(hw_evt)) == $past(hw_evt)));
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r6_quiet_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !eoi) |=> !irq);
endmodule

// File: rtl/ecc_sat_counter.sv
`timescale 1ns/1ps
module ecc_sat_counter
  import ecc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W:0]   up,
  input  logic [CNT_W-1:0] down,
  output logic [CNT_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= sat_step(value, up, down);
  end

  a_r7_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (value == CNT_W'(CNT_MAX) && down == '0) |=> (value == CNT_W'(CNT_MAX)));
  a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (value == '0 && up == '0) |=> (value == '0));
endmodule

// File: rtl/ecc_irq_regs.sv
`timescale 1ns/1ps
module ecc_irq_regs
  import ecc_irq_pkg::*;
#(
  parameter int          NUM_RAMS = 4,
  parameter int          SEL_W    = 11,
  parameter int          RADDR_W  = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] REV_ID   = 32'h66A03201
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_RAMS-1:0] sec_evt,
  input  logic [NUM_RAMS-1:0] ded_evt,
  input  logic                par_err,
  input  logic                tmo_err,
  output logic                sec_irq,
  output logic                ded_irq,
  output logic                agg_irq,
  output logic                rd_go,
  input  logic                rd_done
);
  localparam int NGRP      = 2;
  localparam int NAGG      = 2;
  localparam int GO_BIT    = 15;
  localparam int RADDR_LSB = 16;
  localparam int DONE_BIT  = RADDR_LSB + RADDR_W;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return reg_wr && (reg_addr == a);
  endfunction

  // ---------------- SEC / DED groups ----------------
  logic [NUM_RAMS-1:0] g_evt  [NGRP];
  logic [NUM_RAMS-1:0] g_pend [NGRP];
  logic [NUM_RAMS-1:0] g_en   [NGRP];
  logic [NGRP-1:0]     g_irq;

  assign g_evt[0] = sec_evt;
  assign g_evt[1] = ded_evt;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(g * 256);
    logic [NUM_RAMS-1:0] w_set, w_clr, w_ens, w_enc;
    logic                w_eoi;
    assign w_set = hit(A_SEC_PEND + OFS) ? reg_wdata[NUM_RAMS-1:0] : '0;
    assign w_clr = hit(A_SEC_PCLR + OFS) ? reg_wdata[NUM_RAMS-1:0] : '0;
    assign w_ens = hit(A_SEC_ENS + OFS)  ? reg_wdata[NUM_RAMS-1:0] : '0;
    assign w_enc = hit(A_SEC_ENC + OFS)  ? reg_wdata[NUM_RAMS-1:0] : '0;
    assign w_eoi = hit(A_SEC_EOI + OFS) && reg_wdata[0];
    ecc_pulse_group #(.N(NUM_RAMS)) u_grp (
      .clk(clk), .rst_n(rst_n), .hw_evt(g_evt[g]), .sw_set(w_set), .sw_clr(w_clr),
      .en_set(w_ens), .en_clr(w_enc), .eoi(w_eoi), .pend(g_pend[g]), .en(g_en[g]),
      .irq(g_irq[g])
    );
  end

  assign sec_irq = g_irq[0];
  assign ded_irq = g_irq[1];

  // ---------------- aggregator fault counters ----------------
  logic [CNT_W-1:0] cnt [NAGG];
  logic [NAGG-1:0]  agg_hw, agg_en, cnt_nz;

  assign agg_hw = {tmo_err, par_err};

  for (genvar f = 0; f < NAGG; f++) begin : g_cnt
    logic [CNT_W-1:0] field;
    logic [CNT_W:0]   up;
    logic [CNT_W-1:0] dn;
    assign field = reg_wdata[f*CNT_W +: CNT_W];
    assign up = (hit(A_AGG_UP) ? {1'b0, field} : '0) + {{CNT_W{1'b0}}, agg_hw[f]};
    assign dn = hit(A_AGG_DN) ? field : '0;
    ecc_sat_counter u_cnt (.clk(clk), .rst_n(rst_n), .up(up), .down(dn), .value(cnt[f]));
    assign cnt_nz[f] = |cnt[f];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) agg_en <= '0;
    else agg_en <= (agg_en & ~(hit(A_AGG_ENC) ? reg_wdata[NAGG-1:0] : '0))
                 | (hit(A_AGG_ENS) ? reg_wdata[NAGG-1:0] : '0);
  end

  assign agg_irq = |(cnt_nz & agg_en);

  // ---------------- vector / indirect read control ----------------
  logic [SEL_W-1:0]   vec_sel;
  logic [RADDR_W-1:0] vec_raddr;
  logic               rd_busy, rd_flag, go_req;

  assign go_req = hit(A_VEC) && reg_wdata[GO_BIT] && !rd_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_sel   <= '0;
      vec_raddr <= '0;
      rd_busy   <= 1'b0;
      rd_flag   <= 1'b0;
      rd_go     <= 1'b0;
    end else begin
      if (hit(A_VEC)) begin
        vec_sel   <= reg_wdata[SEL_W-1:0];
        vec_raddr <= reg_wdata[RADDR_LSB +: RADDR_W];
      end
      rd_go <= go_req;
      if (rd_done)     rd_busy <= 1'b0;
      else if (go_req) rd_busy <= 1'b1;
      if (rd_done)         rd_flag <= 1'b1;
      else if (hit(A_VEC)) rd_flag <= 1'b0;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_REV:  reg_rdata = REV_ID;
      A_INFO: reg_rdata[SEL_W-1:0] = SEL_W'(NUM_RAMS);
      A_VEC: begin
        reg_rdata[SEL_W-1:0]              = vec_sel;
        reg_rdata[GO_BIT]                 = rd_busy;
        reg_rdata[RADDR_LSB +: RADDR_W]   = vec_raddr;
        reg_rdata[DONE_BIT]               = rd_flag;
      end
      A_SEC_PEND, A_SEC_PCLR: reg_rdata[NUM_RAMS-1:0] = g_pend[0];
      A_SEC_ENS,  A_SEC_ENC:  reg_rdata[NUM_RAMS-1:0] = g_en[0];
      A_DED_PEND, A_DED_PCLR: reg_rdata[NUM_RAMS-1:0] = g_pend[1];
      A_DED_ENS,  A_DED_ENC:  reg_rdata[NUM_RAMS-1:0] = g_en[1];
      A_AGG_ENS,  A_AGG_ENC:  reg_rdata[NAGG-1:0]     = agg_en;
      A_AGG_UP,   A_AGG_DN:   reg_rdata[NAGG*CNT_W-1:0] = {cnt[1], cnt[0]};
      default: reg_rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

  a_r9_quiet_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_nz == '0) |-> !agg_irq);
  a_r10_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> rd_flag);
  a_r10_go_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go);
endmodule

// File: tb/ecc_irq_regs_test.sv
`timescale 1ns/1ps
module ecc_irq_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  sec_evt = '0, ded_evt = '0;
  logic        par_err = 1'b0, tmo_err = 1'b0;
  logic        sec_irq, ded_irq, agg_irq, rd_go;
  logic        rd_done = 1'b0;

  int checks = 0, errors = 0;
  int sec_pulses = 0, ded_pulses = 0, gos = 0, dly = 0;

  always #5 clk = ~clk;

  ecc_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_evt(sec_evt), .ded_evt(ded_evt),
    .par_err(par_err), .tmo_err(tmo_err), .sec_irq(sec_irq), .ded_irq(ded_irq),
    .agg_irq(agg_irq), .rd_go(rd_go), .rd_done(rd_done)
  );

  // pulse counters and stub indirect-read responder (done 5 cycles after go)
  always @(negedge clk) begin
    if (sec_irq) sec_pulses++;
    if (ded_irq) ded_pulses++;
    rd_done = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) rd_done = 1'b1;
    end
    if (rd_go) begin
      gos++;
      dly = 5;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {req, write, addr, data, expected}
  localparam int NV = 17;
  localparam logic [80:0] VEC [NV] = '{
    {4'd1,  1'b0, 12'h000, 32'h0, 32'h66A03201},   // R1 identity
    {4'd1,  1'b0, 12'h00C, 32'h0, 32'h00000004},   // R1 RAM count
    {4'd1,  1'b0, 12'h208, 32'h0, 32'h00000000},   // R1 counters zero
    {4'd2,  1'b0, 12'h040, 32'h0, 32'h00000000},   // R2 pending zero
    {4'd2,  1'b1, 12'h040, 32'hFFFFFFF5, 32'h0},   // R2 software set
    {4'd2,  1'b0, 12'h040, 32'h0, 32'h00000005},   // R2 upper bits zero
    {4'd2,  1'b1, 12'h044, 32'h00000001, 32'h0},   // R2 clear path
    {4'd2,  1'b0, 12'h044, 32'h0, 32'h00000004},   // R2 read at clear addr
    {4'd3,  1'b1, 12'h180, 32'h00000006, 32'h0},   // R3 set two
    {4'd3,  1'b1, 12'h1C0, 32'h00000002, 32'h0},   // R3 clear one
    {4'd3,  1'b0, 12'h180, 32'h0, 32'h00000004},   // R3 set addr reads mask
    {4'd3,  1'b0, 12'h1C0, 32'h0, 32'h00000004},   // R3 clear addr reads mask
    {4'd3,  1'b1, 12'h180, 32'h00000000, 32'h0},   // R3 zero write
    {4'd3,  1'b0, 12'h180, 32'h0, 32'h00000004},   // R3 unchanged
    {4'd10, 1'b1, 12'h008, 32'h00AB07FF, 32'h0},   // R10 select/address
    {4'd10, 1'b0, 12'h008, 32'h0, 32'h00AB07FF},   // R10 readback
    {4'd3,  1'b1, 12'h1C0, 32'h00000004, 32'h0}    // R3 tidy up
  };

  initial begin
    logic [3:0]  rq;
    logic        w;
    logic [11:0] a;
    logic [31:0] d, e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state of outputs
    chk("R1 sec_irq", {31'b0, sec_irq}, 32'h0);
    chk("R1 ded_irq", {31'b0, ded_irq}, 32'h0);
    chk("R1 agg_irq", {31'b0, agg_irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      {rq, w, a, d, e} = VEC[i];
      if (w) wr_reg(a, d);
      else rd_chk($sformatf("R%0d table row %0d", rq, i), a, e);
    end
    wr_reg(12'h044, 32'hF);

    // R5: pending but disabled gives no pulse
    idle(3);
    chk("R5 no pulse while disabled", sec_pulses, 0);

    // R5 pulse on enabled event
    wr_reg(12'h080, 32'h1);
    @(negedge clk) sec_evt = 4'h1;
    @(negedge clk) sec_evt = 4'h0;
    idle(3);
    chk("R5 first pulse", sec_pulses, 1);

    // R6 no pulse before EOI
    wr_reg(12'h080, 32'h2);
    @(negedge clk) sec_evt = 4'h2;
    @(negedge clk) sec_evt = 4'h0;
    idle(3);
    chk("R6 blocked until EOI", sec_pulses, 1);
    wr_reg(12'h03C, 32'h1);
    idle(3);
    chk("R6 re-trigger after EOI", sec_pulses, 2);

    // R6 EOI with nothing pending
    wr_reg(12'h044, 32'hF);
    wr_reg(12'h03C, 32'h1);
    idle(3);
    chk("R6 EOI with nothing pending", sec_pulses, 2);

    // R2 hardware set, R5 gated by enable, then enabling fires
    @(negedge clk) sec_evt = 4'h4;
    @(negedge clk) sec_evt = 4'h0;
    idle(3);
    chk("R5 disabled event", sec_pulses, 2);
    rd_chk("R2 hardware set", 12'h040, 32'h4);
    wr_reg(12'h080, 32'h4);
    idle(3);
    chk("R5 fire on enable", sec_pulses, 3);

    // R5 DED kind independent
    wr_reg(12'h180, 32'h1);
    @(negedge clk) ded_evt = 4'h1;
    @(negedge clk) ded_evt = 4'h0;
    idle(3);
    chk("R5 ded pulse", ded_pulses, 1);
    chk("R5 sec untouched", sec_pulses, 3);

    // R4 hardware set and software clear in one cycle
    @(negedge clk);
    reg_addr = 12'h144; reg_wdata = 32'h2; reg_wr = 1'b1; ded_evt = 4'h2;
    @(negedge clk);
    reg_wr = 1'b0; ded_evt = 4'h0;
    rd_chk("R4 set wins", 12'h140, 32'h3);
    wr_reg(12'h144, 32'h3);
    rd_chk("R2 cleared", 12'h140, 32'h0);

    // R7 counters
    wr_reg(12'h208, 32'h3);
    rd_chk("R7 add 3", 12'h208, 32'h3);
    wr_reg(12'h208, 32'h1);
    rd_chk("R7 saturate high", 12'h208, 32'h3);
    wr_reg(12'h20C, 32'h2);
    rd_chk("R7 subtract", 12'h20C, 32'h1);
    wr_reg(12'h20C, 32'h3);
    rd_chk("R7 saturate low", 12'h208, 32'h0);
    wr_reg(12'h208, 32'h8);
    rd_chk("R7 timeout field", 12'h208, 32'h8);

    // R9 level interrupt
    chk("R9 disabled", {31'b0, agg_irq}, 32'h0);
    wr_reg(12'h200, 32'h2);
    chk("R9 enabled timeout", {31'b0, agg_irq}, 32'h1);
    rd_chk("R9 mask at clear addr", 12'h204, 32'h2);
    wr_reg(12'h204, 32'h2);
    chk("R9 disabled again", {31'b0, agg_irq}, 32'h0);
    rd_chk("R9 mask cleared", 12'h200, 32'h0);

    // R8 hardware increments and same-cycle net change
    @(negedge clk) par_err = 1'b1;
    @(negedge clk) par_err = 1'b0;
    @(negedge clk) par_err = 1'b1;
    @(negedge clk) par_err = 1'b0;
    rd_chk("R8 two parity faults", 12'h20C, 32'hA);
    @(negedge clk);
    reg_addr = 12'h20C; reg_wdata = 32'h1; reg_wr = 1'b1; par_err = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; par_err = 1'b0;
    rd_chk("R8 fault with down write", 12'h208, 32'hA);
    wr_reg(12'h200, 32'h1);
    chk("R9 parity enabled", {31'b0, agg_irq}, 32'h1);
    wr_reg(12'h20C, 32'h3);
    chk("R9 parity zero", {31'b0, agg_irq}, 32'h0);
    @(negedge clk) tmo_err = 1'b1;
    @(negedge clk) tmo_err = 1'b0;
    @(negedge clk) tmo_err = 1'b1;
    @(negedge clk) tmo_err = 1'b0;
    rd_chk("R8 timeout saturates", 12'h208, 32'hC);

    // R10 indirect read
    wr_reg(12'h008, 32'h00128007);
    rd_chk("R10 busy", 12'h008, 32'h00128007);
    idle(10);
    rd_chk("R10 done", 12'h008, 32'h01120007);
    chk("R10 one go pulse", gos, 1);
    wr_reg(12'h008, 32'h00120007);
    rd_chk("R10 done cleared", 12'h008, 32'h00120007);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule